// File: doc/BRIEF.md
# Multi-Mode Timer/Counter

This block is a parameterised up-counter (16 bits by default) that runs in one of three modes. In interval mode it counts up to a programmed reference value, then returns to zero and toggles its output pin. In capture mode it records the running count in the data register whenever a chosen edge arrives on an external input. In PWM mode it runs freely across the whole count range and drives the output pin high while the reference is above the count. A fourth mode code parks the counter at zero.

The count advances only on cycles where the prescale tick is high, so the clock divider is supplied from outside. Two sticky pending flags report events to an interrupt controller. The overflow flag clears by a software strobe or by a hardware acknowledge. The match/capture flag clears only by its software strobe. The block has no streaming data path, so there is no valid/ready handshake and no back-pressure. Every pin is a plain level or a single-cycle strobe that is sampled on the rising clock edge. A write strobe loads the shared reference/data register.

Top module: `tmr16_multimode`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, the count, data register, output pin and both pending flags are all zero.
- R2: In modes 0, 1 and 2, the count rises by exactly one on each clock edge where `tick_i` is high. When `tick_i` is low the count keeps its value.
- R3: Interval mode (`mode_i` = 0): a tick taken while the count equals the reference returns the count to zero, inverts `out_o` and sets `mc_pend_o`, all on that same edge.
- R4: Capture mode (`mode_i` = 1): `cap_fall_i` = 0 selects rising edges of `cap_pin_i` and `cap_fall_i` = 1 selects falling edges. A selected edge copies the count into `data_o` and sets `mc_pend_o` on the third rising clock edge after the pin changes. An edge of the other polarity changes neither.
- R5: A write strobe `ref_we_i` loads `ref_wdata_i` into the data register on the next edge. If a capture load falls on the same edge, the capture value is kept.
- R6: In modes 1 and 2, a tick at count 0xFFFF wraps the count to 0x0000 and sets `ovf_pend_o`.
- R7: PWM mode (`mode_i` = 2): a tick at count equal to the reference sets `mc_pend_o`, and the count still rises by one.
- R8: In PWM mode, `out_o` becomes (reference > count) one clock after the count or the reference takes its value. It is low when the reference is less than or equal to the count.
- R9: `ovf_pend_o` stays set until a cycle with `ovf_clr_i` or `ovf_ack_i` high. Either one clears it on that edge.
- R10: `mc_pend_o` stays set until a cycle with `mc_clr_i` high. `ovf_clr_i` and `ovf_ack_i` have no effect on it.
- R11: When a set event and a clear strobe for the same pending flag fall on the same edge, the flag ends up set.
- R12: A cycle with `cnt_clr_i` high, or a cycle in which `mode_i` differs from the mode already in force, forces the count to zero and `out_o` low on that edge. No event is raised in that cycle.
- R13: Mode 3 holds the count at zero and `out_o` low, whatever `tick_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescale tick that enables the count for one cycle |
| mode_i | input | 2 | 0 interval, 1 capture, 2 PWM, 3 parked |
| cap_pin_i | input | 1 | Asynchronous capture input |
| cap_fall_i | input | 1 | Capture edge select: 0 rising, 1 falling |
| ref_we_i | input | 1 | Write strobe for the reference/data register |
| ref_wdata_i | input | 16 | Value written to the reference/data register |
| cnt_clr_i | input | 1 | Restart strobe: count to zero, output low |
| ovf_clr_i | input | 1 | Software clear for the overflow flag |
| ovf_ack_i | input | 1 | Hardware service acknowledge for the overflow flag |
| mc_clr_i | input | 1 | Software clear for the match/capture flag |
| out_o | output | 1 | Toggle output (interval mode) or PWM output |
| cnt_o | output | 16 | Current count |
| data_o | output | 16 | Reference/data register |
| ovf_pend_o | output | 1 | Overflow pending |
| mc_pend_o | output | 1 | Match/capture pending |

## Verification
Most results are due on the first rising edge after the stimulus. These include the count step, the interval restart and toggle, the flag sets and clears, register writes and the restart strobe. The PWM output takes one more edge, and a capture load lands on the third edge after the pin changes. Inputs are driven on the falling edge, and every check is sampled on a later falling edge placed at exactly that count of rising edges. A capture check is also sampled one edge early, to confirm nothing arrives ahead of time. The tick is held low around captures so that the expected captured value is fixed.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  typedef enum logic [1:0] {
    MODE_INTERVAL = 2'd0,
    MODE_CAPTURE  = 2'd1,
    MODE_PWM      = 2'd2,
    MODE_PARK     = 2'd3
  } tmr_mode_e;

endpackage

// File: rtl/tmr16_cap_sync.sv
module tmr16_cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;
  assign fall_o = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/tmr16_count.sv
module tmr16_count
  import tmr16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart_i,
  input  logic         tick_i,
  input  tmr_mode_e    mode_i,
  input  logic [W-1:0] ref_i,
  output logic [W-1:0] cnt_o,
  output logic         match_o,
  output logic         wrap_o
);

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic         run;
  logic         at_ref;
  logic         compare_on;
  logic         reload;

  assign run        = tick_i & ~restart_i & (mode_i != MODE_PARK);
  assign at_ref     = (cnt_q == ref_i);
  assign compare_on = (mode_i == MODE_INTERVAL) | (mode_i == MODE_PWM);
  assign match_o    = run & at_ref & compare_on;
  assign reload     = match_o & (mode_i == MODE_INTERVAL);
  assign wrap_o     = run & (cnt_q == CNT_MAX) & ~reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (restart_i)                cnt_q <= '0;
    else if (mode_i == MODE_PARK)      cnt_q <= '0;
    else if (reload)                   cnt_q <= '0;
    else if (run)                      cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/tmr16_outpin.sv
module tmr16_outpin
  import tmr16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart_i,
  input  tmr_mode_e    mode_i,
  input  logic         match_i,
  input  logic [W-1:0] ref_i,
  input  logic [W-1:0] cnt_i,
  output logic         out_o
);

  logic out_q;
  logic out_d;

  always_comb begin
    out_d = out_q;
    if (restart_i) begin
      out_d = 1'b0;
    end else begin
      unique case (mode_i)
        MODE_INTERVAL: if (match_i) out_d = ~out_q;
        MODE_PWM:      out_d = (ref_i > cnt_i);
        default:       out_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign out_o = out_q;

endmodule

// File: rtl/tmr16_pend.sv
module tmr16_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_a_i,
  input  logic clr_b_i,
  output logic pend_o
);

  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   pend_q <= 1'b0;
    else if (set_i)               pend_q <= 1'b1;
    else if (clr_a_i | clr_b_i)   pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/tmr16_multimode.sv
module tmr16_multimode
  import tmr16_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic [1:0]   mode_i,
  input  logic         cap_pin_i,
  input  logic         cap_fall_i,
  input  logic         ref_we_i,
  input  logic [W-1:0] ref_wdata_i,
  input  logic         cnt_clr_i,
  input  logic         ovf_clr_i,
  input  logic         ovf_ack_i,
  input  logic         mc_clr_i,
  output logic         out_o,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] data_o,
  output logic         ovf_pend_o,
  output logic         mc_pend_o
);

  logic [1:0]   mode_q;
  tmr_mode_e    mode_act;
  logic         restart;
  logic         cap_rise;
  logic         cap_fall;
  logic         cap_evt;
  logic         match;
  logic         wrap;
  logic [W-1:0] cnt;
  logic [W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 2'd0;
    else        mode_q <= mode_i;
  end

  assign mode_act = tmr_mode_e'(mode_q);
  assign restart  = cnt_clr_i | (mode_i != mode_q);

  tmr16_cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (cap_pin_i),
    .rise_o (cap_rise),
    .fall_o (cap_fall)
  );

  assign cap_evt = (mode_act == MODE_CAPTURE) & ~restart &
                   (cap_fall_i ? cap_fall : cap_rise);

  tmr16_count #(.W(W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart),
    .tick_i    (tick_i),
    .mode_i    (mode_act),
    .ref_i     (data_q),
    .cnt_o     (cnt),
    .match_o   (match),
    .wrap_o    (wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data_q <= '0;
    else if (cap_evt)  data_q <= cnt;
    else if (ref_we_i) data_q <= ref_wdata_i;
  end

  tmr16_outpin #(.W(W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart),
    .mode_i    (mode_act),
    .match_i   (match),
    .ref_i     (data_q),
    .cnt_i     (cnt),
    .out_o     (out_o)
  );

  tmr16_pend u_ovf_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (wrap),
    .clr_a_i (ovf_clr_i),
    .clr_b_i (ovf_ack_i),
    .pend_o  (ovf_pend_o)
  );

  tmr16_pend u_mc_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (match | cap_evt),
    .clr_a_i (mc_clr_i),
    .clr_b_i (1'b0),
    .pend_o  (mc_pend_o)
  );

  assign cnt_o  = cnt;
  assign data_o = data_q;

endmodule

// File: rtl/tmr16_multimode_chk.sv
module tmr16_multimode_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_i,
  input logic [1:0]   mode_i,
  input logic [1:0]   mode_q,
  input logic         cnt_clr_i,
  input logic         mc_clr_i,
  input logic [W-1:0] cnt_o,
  input logic [W-1:0] data_o,
  input logic         out_o,
  input logic         mc_pend_o,
  input logic         ovf_pend_o
);

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic steady;
  assign steady = (mode_i == mode_q) & ~cnt_clr_i;

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (steady && !tick_i) |=> $stable(cnt_o));  // R2

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr_i |=> (cnt_o == '0) && !out_o);  // R12

  AST_MC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_pend_o && !mc_clr_i) |=> mc_pend_o);  // R10

  AST_PWM_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (steady && mode_q == 2'd2 && tick_i && cnt_o == data_o && cnt_o != CNT_MAX)
    |=> (cnt_o == $past(cnt_o) + 1'b1) && mc_pend_o);  // R7

  AST_PWM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (steady && mode_q == 2'd2 && tick_i && cnt_o == CNT_MAX)
    |=> ovf_pend_o && (cnt_o == '0));  // R6

  AST_PARK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd3) |-> (cnt_o == '0) && !out_o);  // R13

endmodule

bind tmr16_multimode tmr16_multimode_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_i     (tick_i),
  .mode_i     (mode_i),
  .mode_q     (mode_q),
  .cnt_clr_i  (cnt_clr_i),
  .mc_clr_i   (mc_clr_i),
  .cnt_o      (cnt_o),
  .data_o     (data_o),
  .out_o      (out_o),
  .mc_pend_o  (mc_pend_o),
  .ovf_pend_o (ovf_pend_o)
);

// File: tb/tmr16_multimode_tb.sv
module tmr16_multimode_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        cap_pin_i = 1'b0;
  logic        cap_fall_i = 1'b0;
  logic        ref_we_i = 1'b0;
  logic [15:0] ref_wdata_i = '0;
  logic        cnt_clr_i = 1'b0;
  logic        ovf_clr_i = 1'b0;
  logic        ovf_ack_i = 1'b0;
  logic        mc_clr_i = 1'b0;
  logic        out_o;
  logic [15:0] cnt_o;
  logic [15:0] data_o;
  logic        ovf_pend_o;
  logic        mc_pend_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmr16_multimode u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .mode_i(mode_i),
    .cap_pin_i(cap_pin_i), .cap_fall_i(cap_fall_i), .ref_we_i(ref_we_i),
    .ref_wdata_i(ref_wdata_i), .cnt_clr_i(cnt_clr_i), .ovf_clr_i(ovf_clr_i),
    .ovf_ack_i(ovf_ack_i), .mc_clr_i(mc_clr_i), .out_o(out_o), .cnt_o(cnt_o),
    .data_o(data_o), .ovf_pend_o(ovf_pend_o), .mc_pend_o(mc_pend_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    tick_i = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic wr_ref(input logic [15:0] v);
    ref_we_i = 1'b1; ref_wdata_i = v;
    @(negedge clk);
    ref_we_i = 1'b0;
  endtask

  task automatic clr_cnt();
    cnt_clr_i = 1'b1; @(negedge clk); cnt_clr_i = 1'b0;
  endtask

  task automatic clr_mc();
    mc_clr_i = 1'b1; @(negedge clk); mc_clr_i = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode_i = m; @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "cnt", cnt_o, 16'h0);
    chk("R1", "data", data_o, 16'h0);
    chk("R1", "out", {15'b0, out_o}, 16'h0);
    chk("R1", "ovf", {15'b0, ovf_pend_o}, 16'h0);
    chk("R1", "mc", {15'b0, mc_pend_o}, 16'h0);
  endtask

  task automatic t_tick_gate();
    wr_ref(16'd100);
    clr_cnt();
    idle(3);
    chk("R2", "cnt held without tick", cnt_o, 16'd0);
    ticks(5);
    chk("R2", "cnt after 5 ticks", cnt_o, 16'd5);
    idle(2);
    chk("R2", "cnt held again", cnt_o, 16'd5);
    chk("R5", "data after write", data_o, 16'd100);
  endtask

  task automatic t_interval();
    wr_ref(16'd3);
    clr_cnt();
    clr_mc();
    ticks(3);
    chk("R3", "cnt at ref", cnt_o, 16'd3);
    chk("R3", "out before match", {15'b0, out_o}, 16'd0);
    chk("R3", "mc before match", {15'b0, mc_pend_o}, 16'd0);
    ticks(1);
    chk("R3", "cnt after match", cnt_o, 16'd0);
    chk("R3", "out toggled", {15'b0, out_o}, 16'd1);
    chk("R3", "mc set", {15'b0, mc_pend_o}, 16'd1);
    clr_mc();
    chk("R10", "mc cleared by sw", {15'b0, mc_pend_o}, 16'd0);
    ticks(4);
    chk("R3", "out toggled back", {15'b0, out_o}, 16'd0);
    chk("R3", "cnt reloaded", cnt_o, 16'd0);
  endtask

  task automatic t_restart();
    ticks(4);
    chk("R12", "out high before clear", {15'b0, out_o}, 16'd1);
    ticks(2);
    clr_cnt();
    chk("R12", "cnt after clear", cnt_o, 16'd0);
    chk("R12", "out after clear", {15'b0, out_o}, 16'd0);
    ticks(2);
    set_mode(2'd2);
    chk("R12", "cnt after mode change", cnt_o, 16'd0);
    chk("R12", "out after mode change", {15'b0, out_o}, 16'd0);
  endtask

  task automatic t_pwm_out();
    idle(1);
    chk("R8", "out high ref3 cnt0", {15'b0, out_o}, 16'd1);
    ticks(3);
    idle(1);
    chk("R8", "out low ref==cnt", {15'b0, out_o}, 16'd0);
    ticks(1);
    idle(1);
    chk("R8", "out low ref<cnt", {15'b0, out_o}, 16'd0);
    wr_ref(16'd10);
    idle(1);
    chk("R8", "out high after ref raise", {15'b0, out_o}, 16'd1);
  endtask

  task automatic t_pwm_match();
    wr_ref(16'd5);
    clr_cnt();
    clr_mc();
    ticks(5);
    chk("R7", "mc before match", {15'b0, mc_pend_o}, 16'd0);
    tick_i = 1'b1; mc_clr_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0; mc_clr_i = 1'b0;
    chk("R7", "cnt not cleared by match", cnt_o, 16'd6);
    chk("R11", "set wins over clear", {15'b0, mc_pend_o}, 16'd1);
  endtask

  task automatic t_pwm_wrap();
    wr_ref(16'h8000);
    clr_cnt();
    clr_mc();
    ticks(65535);
    chk("R6", "cnt at max", cnt_o, 16'hFFFF);
    chk("R6", "ovf before wrap", {15'b0, ovf_pend_o}, 16'd0);
    ticks(1);
    chk("R6", "cnt wrapped", cnt_o, 16'h0000);
    chk("R6", "ovf set", {15'b0, ovf_pend_o}, 16'd1);
    chk("R7", "mc from match on the way", {15'b0, mc_pend_o}, 16'd1);
    idle(2);
    chk("R9", "ovf sticky", {15'b0, ovf_pend_o}, 16'd1);
    ovf_ack_i = 1'b1; @(negedge clk); ovf_ack_i = 1'b0;
    chk("R9", "ovf cleared by ack", {15'b0, ovf_pend_o}, 16'd0);
    chk("R10", "mc unaffected by ack", {15'b0, mc_pend_o}, 16'd1);
  endtask

  task automatic t_capture();
    set_mode(2'd1);
    clr_mc();
    cap_fall_i = 1'b0;
    ticks(7);
    cap_pin_i = 1'b1;
    idle(2);
    chk("R4", "no capture before 3rd edge", data_o, 16'h8000);
    idle(1);
    chk("R4", "rising capture", data_o, 16'd7);
    chk("R4", "mc set by capture", {15'b0, mc_pend_o}, 16'd1);
    clr_mc();
    ticks(2);
    cap_pin_i = 1'b0;
    idle(4);
    chk("R4", "falling ignored data", data_o, 16'd7);
    chk("R4", "falling ignored mc", {15'b0, mc_pend_o}, 16'd0);
    wr_ref(16'h1234);
    chk("R5", "write in capture mode", data_o, 16'h1234);
    cap_fall_i = 1'b1;
    cap_pin_i = 1'b1;
    idle(4);
    chk("R4", "rising ignored with fall select", data_o, 16'h1234);
    ticks(3);
    cap_pin_i = 1'b0;
    idle(2);
    ref_we_i = 1'b1; ref_wdata_i = 16'hBEEF;
    @(negedge clk);
    ref_we_i = 1'b0;
    chk("R5", "capture wins over write", data_o, 16'd12);
    chk("R4", "falling capture mc", {15'b0, mc_pend_o}, 16'd1);
  endtask

  task automatic t_cap_wrap();
    clr_cnt();
    ticks(65536);
    chk("R6", "capture-mode wrap cnt", cnt_o, 16'h0000);
    chk("R6", "capture-mode ovf", {15'b0, ovf_pend_o}, 16'd1);
    ovf_clr_i = 1'b1; @(negedge clk); ovf_clr_i = 1'b0;
    chk("R9", "ovf cleared by sw", {15'b0, ovf_pend_o}, 16'd0);
    chk("R10", "mc unaffected by ovf clear", {15'b0, mc_pend_o}, 16'd1);
  endtask

  task automatic t_park();
    set_mode(2'd3);
    ticks(5);
    chk("R13", "parked cnt", cnt_o, 16'd0);
    chk("R13", "parked out", {15'b0, out_o}, 16'd0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    idle(3);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tick_gate();
    t_interval();
    t_restart();
    t_pwm_out();
    t_pwm_match();
    t_pwm_wrap();
    t_capture();
    t_cap_wrap();
    t_park();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule